// File: doc/BRIEF.md
# Game-Port Serial Host Controller

This block is the host side of a byte-swapping serial port that serves two slots. Each slot carries a primary input device and a secondary storage device. Software queues outgoing bytes in an eight-entry transmit queue through a small register bus. While the port is selected and transmission is enabled, a byte timer paces the traffic. At the end of every byte period the oldest queued byte is swapped with one device. The byte that comes back, or 0xFF when nothing answers, lands in an eight-entry receive queue.

Device choice is sticky. When no device owns the exchange, the primary device of the selected slot is strobed first. The storage device is strobed only when the primary stays silent. Whichever device acknowledges keeps the exchange until it misses an acknowledge. Acknowledges collect in a flag that survives until software reads status. While that flag is set and its enable is on, every completed byte raises an interrupt flag and a one-cycle request pulse.

Top module: `gp_host`

## Requirements
- R1: After reset the status register reads 0x5, control and mode read 0, `irq_o` is low and no device strobe is active.
- R2: Reads decode offset 0x00 as receive data, 0x04 as status, 0x08 as mode (16 bits, upper bits written are dropped) and 0x0A as control (16 bits). Any other offset, including 0x0E, reads 0xFFFFFFFF.
- R3: A write to offset 0x0E is accepted and changes no register, queue or transfer.
- R4: A data read returns the oldest received byte, zero-extended, and removes it. A data read while the receive queue is empty returns 0.
- R5: Status bit 0 shows that the transmit queue is not full. Bit 1 shows that the receive queue is not empty. Bit 2 shows that the transmit queue is empty. Bit 7 is the sticky acknowledge flag and bit 9 is the interrupt flag. A status read returns the current value and then clears bit 7.
- R6: A data write to a full transmit queue drops the oldest stored byte and keeps the new one, so the last eight bytes written are sent in order.
- R7: Control bit 0 enables transmission and bit 1 selects the port. A data or control write that leaves both set, with the port idle and bytes queued, starts a transfer and sets control bit 2. The received byte is visible exactly BYTE_CLKS+2 cycles after the starting write.
- R8: The device index is 2*slot+kind, where control bit 13 gives the slot and kind 0 is primary. With no owner, the primary device is tried first and the storage device second. A byte that no device acknowledges is received as 0xFF.
- R9: A device that acknowledges owns the exchange. While it is the owner, the other device of the slot is never strobed. The first unacknowledged byte ends ownership.
- R10: While bit 7 is set after a byte and control bit 12 is set, that byte sets status bit 9 and pulses `irq_o` for one cycle. A control write with bit 4 set clears bit 9.
- R11: A control write that clears bit 1 pulses `dev_rst_o` for one cycle, drops the owner and halts the transfer. Queued transmit bytes stay and are sent once the port is selected again.
- R12: A control write with bit 6 set clears control, mode and status, empties both queues and halts any transfer.
- R13: At most one device strobe is active at a time. `dev_txd_o` carries the transmit byte being exchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| dev_strobe_o | output | 4 | One exchange strobe per device, index 2*slot+kind |
| dev_txd_o | output | 8 | Byte sent to the strobed device |
| dev_ack_i | input | 4 | Device acknowledge, due one cycle after its strobe |
| dev_rxd_i | input | 32 | Device reply bytes, device i at bits 8i+7..8i |
| dev_rst_o | output | 1 | One-cycle pulse that resets every device's exchange state |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
The hardest situation to reach is an owner that stops acknowledging while the other device of the same slot would answer. This state needs a history of earlier bytes and cannot be set directly from the ports. The bench reaches it with a device model whose presence and acknowledge budget change between bytes. It first lets the storage device win, then makes the primary present, and then exhausts the storage budget, so the silent byte shows 0xFF. A sweep over both slots and every presence pattern covers the priority order. Further bursts cover a deselect in mid-transfer and overflow of the transmit queue.

// File: rtl/gp_pkg.sv
package gp_pkg;
  localparam int N_SLOTS = 2;
  localparam int N_DEV   = 2 * N_SLOTS;

  localparam logic [3:0] OFF_DATA = 4'h0;
  localparam logic [3:0] OFF_STAT = 4'h4;
  localparam logic [3:0] OFF_MODE = 4'h8;
  localparam logic [3:0] OFF_CTRL = 4'hA;
  localparam logic [3:0] OFF_RATE = 4'hE;

  localparam int CB_TXEN = 0;
  localparam int CB_SEL  = 1;
  localparam int CB_RXEN = 2;
  localparam int CB_CLRI = 4;
  localparam int CB_SRST = 6;
  localparam int CB_AIE  = 12;
  localparam int CB_SLOT = 13;

  localparam int SB_TXRDY  = 0;
  localparam int SB_RXNE   = 1;
  localparam int SB_TXDONE = 2;
  localparam int SB_ACKIN  = 7;
  localparam int SB_INTR   = 9;

  typedef enum logic [1:0] {XS_IDLE, XS_WAIT, XS_STRB, XS_SAMP} xstate_t;
endpackage

// File: rtl/gp_fifo.sv
module gp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o,
  output logic [$clog2(DEPTH):0] cnt_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          take;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign dout_o  = mem_q[rp_q];
  assign cnt_o   = cnt_q;

  // a push into a full queue without a pop drops the oldest entry
  always_comb begin
    take  = (pop_i && !empty_o) || (push_i && full_o);
    wp_d  = push_i ? wp_q + 1'b1 : wp_q;
    rp_d  = take ? rp_q + 1'b1 : rp_q;
    cnt_d = cnt_q + (push_i ? 1'b1 : 1'b0) - (take ? 1'b1 : 1'b0);
    if (clr_i) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i && !clr_i) mem_q[wp_q] <= din_i;
  end
endmodule

// File: rtl/gp_xfer.sv
module gp_xfer
  import gp_pkg::*;
#(
  parameter int BYTE_CLKS = 1088
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             clr_owner_i,
  input  logic             slot_i,
  input  logic             tx_empty_i,
  input  logic             tx_avail_i,
  input  logic [7:0]       tx_byte_i,
  output logic             tx_pop_o,
  output logic [N_DEV-1:0] dev_strobe_o,
  output logic [7:0]       dev_txd_o,
  input  logic [N_DEV-1:0] dev_ack_i,
  input  logic [8*N_DEV-1:0] dev_rxd_i,
  output logic             done_o,
  output logic             ack_o,
  output logic [7:0]       rx_byte_o,
  output logic             busy_o
);
  localparam int CNT_W = $clog2(BYTE_CLKS + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BYTE_CLKS - 1);

  xstate_t          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             kind_q, kind_d;
  logic             own_v_q, own_v_d, own_k_q, own_k_d;
  logic [7:0]       txd_q, txd_d;
  logic [1:0]       idx;
  logic             hit;

  assign idx          = {slot_i, kind_q};
  assign hit          = dev_ack_i[idx];
  assign ack_o        = hit;
  assign rx_byte_o    = hit ? dev_rxd_i[idx*8 +: 8] : 8'hFF;
  assign dev_strobe_o = (st_q == XS_STRB) ? (N_DEV'(1) << idx) : '0;
  assign dev_txd_o    = txd_q;
  assign busy_o       = (st_q != XS_IDLE);

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    kind_d   = kind_q;
    own_v_d  = own_v_q;
    own_k_d  = own_k_q;
    txd_d    = txd_q;
    tx_pop_o = 1'b0;
    done_o   = 1'b0;
    unique case (st_q)
      XS_IDLE: if (start_i) begin
        st_d  = XS_WAIT;
        cnt_d = RELOAD;
      end
      XS_WAIT: if (cnt_q == '0) begin
        if (tx_empty_i) st_d = XS_IDLE;
        else begin
          tx_pop_o = 1'b1;
          txd_d    = tx_byte_i;
          kind_d   = own_v_q ? own_k_q : 1'b0;
          st_d     = XS_STRB;
        end
      end else cnt_d = cnt_q - 1'b1;
      XS_STRB: st_d = XS_SAMP;
      XS_SAMP: if (!hit && !own_v_q && !kind_q) begin
        kind_d = 1'b1;               // primary silent: try storage device
        st_d   = XS_STRB;
      end else begin
        done_o  = 1'b1;
        own_v_d = hit;
        own_k_d = kind_q;
        if (tx_avail_i) begin
          st_d  = XS_WAIT;
          cnt_d = RELOAD;
        end else st_d = XS_IDLE;
      end
      default: st_d = XS_IDLE;
    endcase
    if (clr_owner_i) own_v_d = 1'b0;
    if (stop_i) begin
      st_d     = XS_IDLE;
      tx_pop_o = 1'b0;
      done_o   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= XS_IDLE;
      cnt_q   <= '0;
      kind_q  <= 1'b0;
      own_v_q <= 1'b0;
      own_k_q <= 1'b0;
      txd_q   <= '0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      kind_q  <= kind_d;
      own_v_q <= own_v_d;
      own_k_q <= own_k_d;
      if (tx_pop_o) txd_q <= txd_d;
    end
  end
endmodule

// File: rtl/gp_host.sv
module gp_host
  import gp_pkg::*;
#(
  parameter int BYTE_CLKS = 1088,
  parameter int Q_DEPTH   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [3:0]  dev_strobe_o,
  output logic [7:0]  dev_txd_o,
  input  logic [3:0]  dev_ack_i,
  input  logic [31:0] dev_rxd_i,
  output logic        dev_rst_o,
  output logic        irq_o
);
  localparam int CW = $clog2(Q_DEPTH) + 1;

  logic [1:0]  rsync_q;
  logic        rst_int_n;
  logic [15:0] ctrl_q, ctrl_d, mode_q, mode_d;
  logic        ackin_q, ackin_d, intr_q, intr_d, irq_q, devrst_q;
  logic        wr_data, wr_mode, wr_ctrl, rd_data, rd_stat, soft_rst;
  logic        sel_n, txen_n, start, stop, fire;
  logic        tx_empty, tx_full, tx_pop, rx_empty, rx_full;
  logic [7:0]  tx_dout, rx_dout, rx_byte;
  logic        x_done, x_ack, x_busy;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [15:0] stat;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  assign wr_data  = bus_req &&  bus_wr && (bus_addr == OFF_DATA);
  assign wr_mode  = bus_req &&  bus_wr && (bus_addr == OFF_MODE);
  assign wr_ctrl  = bus_req &&  bus_wr && (bus_addr == OFF_CTRL);
  assign rd_data  = bus_req && !bus_wr && (bus_addr == OFF_DATA);
  assign rd_stat  = bus_req && !bus_wr && (bus_addr == OFF_STAT);
  assign soft_rst = wr_ctrl && bus_wdata[CB_SRST];

  assign sel_n  = wr_ctrl ? (bus_wdata[CB_SEL]  && !soft_rst) : ctrl_q[CB_SEL];
  assign txen_n = wr_ctrl ? (bus_wdata[CB_TXEN] && !soft_rst) : ctrl_q[CB_TXEN];
  assign stop   = wr_ctrl && !(sel_n && txen_n);
  assign start  = (wr_data || wr_ctrl) && sel_n && txen_n && !x_busy
                  && (!tx_empty || wr_data);
  assign fire   = x_done && (ackin_q || x_ack) && ctrl_q[CB_AIE];

  gp_fifo #(.W(8), .DEPTH(Q_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_int_n), .clr_i(soft_rst), .push_i(wr_data),
    .pop_i(tx_pop), .din_i(bus_wdata[7:0]), .dout_o(tx_dout),
    .empty_o(tx_empty), .full_o(tx_full), .cnt_o(tx_cnt));

  gp_fifo #(.W(8), .DEPTH(Q_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_int_n), .clr_i(soft_rst), .push_i(x_done),
    .pop_i(rd_data), .din_i(rx_byte), .dout_o(rx_dout),
    .empty_o(rx_empty), .full_o(rx_full), .cnt_o(rx_cnt));

  gp_xfer #(.BYTE_CLKS(BYTE_CLKS)) u_xfer (
    .clk(clk), .rst_n(rst_int_n), .start_i(start), .stop_i(stop),
    .clr_owner_i(wr_ctrl && !sel_n), .slot_i(ctrl_q[CB_SLOT]),
    .tx_empty_i(tx_empty), .tx_avail_i(!tx_empty || wr_data),
    .tx_byte_i(tx_dout), .tx_pop_o(tx_pop), .dev_strobe_o(dev_strobe_o),
    .dev_txd_o(dev_txd_o), .dev_ack_i(dev_ack_i), .dev_rxd_i(dev_rxd_i),
    .done_o(x_done), .ack_o(x_ack), .rx_byte_o(rx_byte), .busy_o(x_busy));

  always_comb begin
    stat            = '0;
    stat[SB_TXRDY]  = !tx_full;
    stat[SB_RXNE]   = !rx_empty;
    stat[SB_TXDONE] = tx_empty;
    stat[SB_ACKIN]  = ackin_q;
    stat[SB_INTR]   = intr_q;
  end

  always_comb begin
    unique case (bus_addr)
      OFF_DATA: bus_rdata = rx_empty ? 32'h0 : {24'h0, rx_dout};
      OFF_STAT: bus_rdata = {16'h0, stat};
      OFF_MODE: bus_rdata = {16'h0, mode_q};
      OFF_CTRL: bus_rdata = {16'h0, ctrl_q};
      default:  bus_rdata = 32'hFFFF_FFFF;
    endcase
  end

  always_comb begin
    ctrl_d  = ctrl_q;
    mode_d  = mode_q;
    ackin_d = ackin_q;
    intr_d  = intr_q;
    if (wr_ctrl) ctrl_d = bus_wdata[15:0];
    if (wr_mode) mode_d = bus_wdata[15:0];
    if (start)   ctrl_d[CB_RXEN] = 1'b1;
    if (rd_stat) ackin_d = 1'b0;
    if (x_done && x_ack) ackin_d = 1'b1;
    if (wr_ctrl && bus_wdata[CB_CLRI]) intr_d = 1'b0;
    if (fire)    intr_d = 1'b1;
    if (soft_rst) begin
      ctrl_d  = '0;
      mode_d  = '0;
      ackin_d = 1'b0;
      intr_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q   <= '0;
      mode_q   <= '0;
      ackin_q  <= 1'b0;
      intr_q   <= 1'b0;
      irq_q    <= 1'b0;
      devrst_q <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      mode_q   <= mode_d;
      ackin_q  <= ackin_d;
      intr_q   <= intr_d;
      irq_q    <= fire;
      devrst_q <= wr_ctrl && !sel_n;
    end
  end

  assign irq_o     = irq_q;
  assign dev_rst_o = devrst_q;
endmodule

// File: rtl/gp_host_chk.sv
module gp_host_chk #(
  parameter int Q_DEPTH = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_o,
  input logic        intr_q,
  input logic [3:0]  dev_strobe_o,
  input logic        dev_rst_o,
  input logic [15:0] ctrl_q,
  input logic [$clog2(Q_DEPTH):0] tx_cnt
);
  // R10: the request is a single-cycle pulse
  a_r10_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  // R10: a request is always backed by the status interrupt flag
  a_r10_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> intr_q);
  // R13: never two devices strobed together
  a_r13_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_strobe_o));
  // R7: exchanges only while selected and enabled
  a_r7_strobe_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_strobe_o != 4'b0) |-> (ctrl_q[1] && ctrl_q[0]));
  // R11: device reset pulse follows a deselect
  a_r11_devrst_desel: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst_o |-> !ctrl_q[1]);
  // R6: transmit queue occupancy never exceeds its depth
  a_r6_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= ($clog2(Q_DEPTH)+1)'(Q_DEPTH));
endmodule

bind gp_host gp_host_chk #(.Q_DEPTH(Q_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .irq_o(irq_o), .intr_q(intr_q),
  .dev_strobe_o(dev_strobe_o), .dev_rst_o(dev_rst_o), .ctrl_q(ctrl_q),
  .tx_cnt(tx_cnt));

// File: tb/gp_host_bench.sv
module gp_host_bench;
  localparam int CLK_P = 10;
  localparam int B     = 12;
  localparam int BW    = B + 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [3:0]  dev_strobe;
  logic [7:0]  dev_txd;
  logic [3:0]  dev_ack = '0;
  logic [31:0] dev_rxd = '0;
  logic        dev_rst, irq;

  int vectors = 0, miscompares = 0, irq_cnt = 0, drst_cnt = 0;
  bit finished = 0;
  logic [3:0] present = '0;
  int budget [4];

  always #(CLK_P/2) clk = ~clk;

  gp_host #(.BYTE_CLKS(B)) u_gp_host (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dev_strobe_o(dev_strobe), .dev_txd_o(dev_txd), .dev_ack_i(dev_ack),
    .dev_rxd_i(dev_rxd), .dev_rst_o(dev_rst), .irq_o(irq));

  // device models: answer one cycle after their strobe
  always @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (dev_strobe[i]) begin
        dev_ack[i] <= present[i] && (budget[i] > 0);
        dev_rxd[i*8 +: 8] <= dev_txd ^ 8'((i + 1) * 16);
        if (present[i] && budget[i] > 0) budget[i] <= budget[i] - 1;
      end else dev_ack[i] <= 1'b0;
    end
    if (irq) irq_cnt++;
    if (dev_rst) drst_cnt++;
  end

  function automatic logic [31:0] resp(int i, logic [7:0] b);
    return {24'h0, b ^ 8'((i + 1) * 16)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic all_budgets(int v);
    for (int i = 0; i < 4; i++) budget[i] = v;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    logic [31:0] v;
    int ic, dc;
    all_budgets(1000);
    waitc(3);
    rst_n = 1'b1;
    waitc(3);

    // R1 reset state
    rd(4'h4, v); chk("R1 status", v, 32'h5);
    rd(4'hA, v); chk("R1 ctrl", v, 32'h0);
    rd(4'h8, v); chk("R1 mode", v, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 strobe", {28'h0, dev_strobe}, 32'h0);

    // R2 map and unmapped reads
    rd(4'hC, v); chk("R2 unmapped 0xC", v, 32'hFFFF_FFFF);
    rd(4'hE, v); chk("R2 read 0xE", v, 32'hFFFF_FFFF);
    rd(4'h2, v); chk("R2 unmapped 0x2", v, 32'hFFFF_FFFF);
    wr(4'h8, 32'hABCD_1234);
    rd(4'h8, v); chk("R2 mode 16-bit", v, 32'h1234);

    // R3 rate register writes change nothing
    wr(4'hE, 32'hFFFF_FFFF);
    rd(4'h8, v); chk("R3 mode kept", v, 32'h1234);
    rd(4'hA, v); chk("R3 ctrl kept", v, 32'h0);
    rd(4'h4, v); chk("R3 status kept", v, 32'h5);

    // R4 empty receive read
    rd(4'h0, v); chk("R4 empty read", v, 32'h0);

    // R7 exact timing, R5 sticky flag cleared by status read
    present = 4'b0001;
    wr(4'hA, 32'h3);
    wr(4'h0, 32'h5A);
    waitc(B);
    rd(4'h4, v); chk("R7 not yet received", v & 32'h2, 32'h0);
    rd(4'h4, v); chk("R7 R5 received with ack", v, 32'h87);
    rd(4'h4, v); chk("R5 ack cleared by read", v, 32'h07);
    rd(4'hA, v); chk("R7 rxen set", v & 32'h4, 32'h4);
    rd(4'h0, v); chk("R7 R13 byte swapped", v, resp(0, 8'h5A));

    // R8 R13 sweep over slots and presence patterns
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < 4; p++) begin
        logic [7:0] b;
        logic [31:0] e;
        b = 8'(16'h21 + s * 64 + p * 9);
        all_budgets(1000);
        present = 4'(p << (2 * s));
        wr(4'hA, 32'h0);
        wr(4'hA, 32'h3 | (s << 13));
        wr(4'h0, {24'h0, b});
        waitc(BW);
        if (p[0]) e = resp(2 * s, b);
        else if (p[1]) e = resp(2 * s + 1, b);
        else e = 32'hFF;
        rd(4'h0, v); chk($sformatf("R8 slot%0d pat%0d data", s, p), v, e);
        rd(4'h4, v); chk($sformatf("R8 slot%0d pat%0d ack", s, p), (v >> 7) & 1, (p != 0) ? 1 : 0);
      end
    end

    // R9 sticky owner
    all_budgets(1000);
    present = 4'b0010;
    wr(4'hA, 32'h0);
    wr(4'hA, 32'h3);
    wr(4'h0, 32'h11); waitc(BW);
    present = 4'b0011;
    wr(4'h0, 32'h22); waitc(BW);
    budget[1] = 0;
    wr(4'h0, 32'h33); waitc(BW);
    wr(4'h0, 32'h44); waitc(BW);
    rd(4'h0, v); chk("R9 storage wins", v, resp(1, 8'h11));
    rd(4'h0, v); chk("R9 owner kept", v, resp(1, 8'h22));
    rd(4'h0, v); chk("R9 owner silent gives FF", v, 32'hFF);
    rd(4'h0, v); chk("R9 primary after release", v, resp(0, 8'h44));

    // R10 interrupt
    all_budgets(1000);
    present = 4'b0001;
    rd(4'h4, v);
    ic = irq_cnt;
    wr(4'hA, 32'h1003);
    wr(4'h0, 32'h66); waitc(BW);
    chk("R10 one pulse", irq_cnt - ic, 1);
    rd(4'h4, v); chk("R10 intr flag", v & 32'h280, 32'h280);
    wr(4'hA, 32'h1013);
    rd(4'h4, v); chk("R10 intr cleared", v & 32'h200, 32'h0);
    present = 4'b0000;
    ic = irq_cnt;
    wr(4'h0, 32'h67); waitc(BW);
    chk("R10 no pulse without ack", irq_cnt - ic, 0);
    rd(4'h0, v); rd(4'h0, v); chk("R10 silent byte", v, 32'hFF);

    // R6 overflow drops the oldest
    present = 4'b0001;
    wr(4'hA, 32'h0);
    for (int i = 0; i < 9; i++) wr(4'h0, 32'h30 + i);
    rd(4'h4, v); chk("R6 full and pending", v & 32'h5, 32'h0);
    wr(4'hA, 32'h3);
    waitc(8 * BW);
    for (int i = 0; i < 8; i++) begin
      rd(4'h0, v); chk($sformatf("R6 order %0d", i), v, resp(0, 8'(8'h31 + i)));
    end

    // R11 deselect mid-transfer
    dc = drst_cnt;
    wr(4'h0, 32'h71); wr(4'h0, 32'h72); wr(4'h0, 32'h73);
    waitc(B + 6);
    wr(4'hA, 32'h1);
    waitc(2);
    chk("R11 device reset pulse", drst_cnt - dc, 1);
    waitc(3 * BW);
    rd(4'h4, v); chk("R11 bytes still queued", v & 32'h4, 32'h0);
    rd(4'h0, v); chk("R11 first byte", v, resp(0, 8'h71));
    rd(4'h0, v); chk("R11 nothing more", v, 32'h0);
    wr(4'hA, 32'h3);
    waitc(3 * BW);
    rd(4'h0, v); chk("R11 resumed 2", v, resp(0, 8'h72));
    rd(4'h0, v); chk("R11 resumed 3", v, resp(0, 8'h73));

    // R12 soft reset
    wr(4'h8, 32'h55AA);
    wr(4'hA, 32'h0);
    wr(4'h0, 32'h81); wr(4'h0, 32'h82);
    wr(4'hA, 32'h1003);
    wr(4'h0, 32'h83);
    waitc(B + 4);
    wr(4'hA, 32'h40);
    waitc(3 * BW);
    rd(4'h4, v); chk("R12 status", v, 32'h5);
    rd(4'hA, v); chk("R12 ctrl", v, 32'h0);
    rd(4'h8, v); chk("R12 mode", v, 32'h0);
    rd(4'h0, v); chk("R12 rx emptied", v, 32'h0);

    summary();
  end
endmodule